// File: doc/BRIEF.md
# Watchdog Timer With Early Warning

This block is a watchdog counter advanced by a slow periodic tick enable. The tick first passes through a divider with a selectable odd factor. A prescaler then divides it by a selectable power of two. When the selected period elapses without a restart, the watchdog expires. Depending on the configured mode, an expiry raises an interrupt flag, issues a one-cycle system reset pulse, or does both in two stages: the first expiry raises the interrupt, and a second expiry that finds it still pending forces the reset.

Software keeps the watchdog alive by pulsing `kick`. It services the interrupt by pulsing `intAck`. An optional early-warning flag marks the first expiry of a sequence. Configuration is presented on plain inputs and captured when `cfgWr` is high. The counters are not cleared by a configuration write, so shortening the period without first kicking can cause an expiry at the very next divided tick.

Top module: `wdt_early_warn`

## Requirements
- R1: After reset, `sysReset`, `intFlag` and `earlyFlag` are low. The captured configuration is: disabled, mode 0, prescale code 0, odd code 0, early warning off.
- R2: Odd-divider codes 0..5 select factors 1, 3, 5, 7, 11 and 13. Codes 6 and 7 select factor 1. If the factor is lowered while the divider count is already at or past the new last step, the next tick completes a divided period.
- R3: With prescale code p (values above 9 act as 9) and odd factor f, an expiry occurs on the f·2^(p+1)-th tick after a restart. The outputs react in the cycle after that tick.
- R4: A `kick` clears the odd divider and the prescaler in the same cycle. A tick in that cycle is ignored and cannot cause an expiry.
- R5: While the captured enable is 0, the counters stay at zero and no expiry occurs, whatever the ticks.
- R6: Mode 0 (interrupt only): an expiry sets `intFlag`. The flag stays set through further expiries until `intAck`, and no reset is issued.
- R7: Mode 1 (reset only): an expiry issues `sysReset`, and `intFlag` is never set.
- R8: Modes 2 and 3 (interrupt then reset): an expiry that finds `intFlag` clear sets it. An expiry that finds it still set (and not acknowledged in that cycle) issues `sysReset` instead.
- R9: At an expiry in modes 0, 2 or 3 that finds `intFlag` clear, `earlyFlag` is set if and only if the captured early-warning enable is 1. `intAck` clears both flags.
- R10: Lowering the prescale code without a kick does not clear the prescaler. If its count is at or beyond the new last step, the next divided tick expires.
- R11: `sysReset` lasts exactly one cycle and clears both flags. Counting then resumes from zero with the configuration retained, so the next expiry comes after the same full period.
- R12: Values on the configuration inputs take effect in the cycle after a `cfgWr` cycle. A tick in the write cycle uses the old configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Slow time-base tick enable, one cycle per tick |
| kick | input | 1 | Restart strobe |
| cfgWr | input | 1 | Configuration capture strobe |
| cfgEnable | input | 1 | Watchdog enable |
| cfgMode | input | 2 | 0 interrupt, 1 reset, 2/3 interrupt then reset |
| cfgPreSel | input | 4 | Power-of-two prescale code |
| cfgOddSel | input | 3 | Odd divider code |
| cfgEarlyEn | input | 1 | Early-warning enable |
| intAck | input | 1 | Interrupt acknowledge, clears both flags |
| sysReset | output | 1 | One-cycle system reset pulse |
| intFlag | output | 1 | Time-out interrupt flag |
| earlyFlag | output | 1 | Early-warning flag |

## Verification
A wrong divider or prescaler count is visible at the ports only at the next expiry, so it can stay hidden for up to one full period. The bench therefore measures exact tick counts from a kick to the reset pulse for several factor and prescale pairs. A wrong flag state shows up within one expiry: a stuck or missing `intFlag` turns a second expiry into a reset, or prevents one, in two-stage mode. Leftover prescaler state after a configuration change shows as a reset one divided tick after the change.

// File: rtl/wdt_ew_pkg.sv
package wdt_ew_pkg;

  typedef enum logic [1:0] {
    MODE_IRQ     = 2'd0,
    MODE_RST     = 2'd1,
    MODE_TWO     = 2'd2,
    MODE_TWO_ALT = 2'd3
  } wdtMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic restart;
    logic hold;
  } dpStrobe_t;

  localparam int ODD_W = 4;

  function automatic logic [ODD_W-1:0] oddFactor(input logic [2:0] sel);
    case (sel)
      3'd1:    oddFactor = 4'd3;
      3'd2:    oddFactor = 4'd5;
      3'd3:    oddFactor = 4'd7;
      3'd4:    oddFactor = 4'd11;
      3'd5:    oddFactor = 4'd13;
      default: oddFactor = 4'd1;
    endcase
  endfunction

endpackage

// File: rtl/wdt_ew_datapath.sv
module wdt_ew_datapath
  import wdt_ew_pkg::*;
#(
  parameter int PSEL_W   = 4,
  parameter int PSEL_MAX = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  dpStrobe_t         strobe,
  input  logic [2:0]        oddSel,
  input  logic [PSEL_W-1:0] preSel,
  output logic              expire
);

  localparam int CNT_W = PSEL_MAX + 1;

  logic [ODD_W-1:0]  oddCnt;
  logic [CNT_W-1:0]  preCnt;
  logic [PSEL_W-1:0] selClamp;
  logic [CNT_W:0]    preLimit;
  logic [CNT_W-1:0]  preLast;
  logic [ODD_W-1:0]  oddLastVal;
  logic              oddLast;
  logic              preHit;
  logic              advance;

  always_comb begin
    selClamp   = (preSel > PSEL_W'(PSEL_MAX)) ? PSEL_W'(PSEL_MAX) : preSel;
    preLimit   = (CNT_W+1)'(2) << selClamp;
    preLast    = CNT_W'(preLimit - 1'b1);
    oddLastVal = oddFactor(oddSel) - 1'b1;
    oddLast    = (oddCnt >= oddLastVal);
    preHit     = (preCnt >= preLast);
    advance    = tick && !strobe.restart && !strobe.hold;
    expire     = advance && oddLast && preHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oddCnt <= '0;
      preCnt <= '0;
    end else if (strobe.restart || strobe.hold) begin
      oddCnt <= '0;
      preCnt <= '0;
    end else if (tick) begin
      if (oddLast) begin
        oddCnt <= '0;
        preCnt <= preHit ? '0 : preCnt + 1'b1;
      end else begin
        oddCnt <= oddCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/wdt_ew_control.sv
module wdt_ew_control
  import wdt_ew_pkg::*;
#(
  parameter int PSEL_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  logic              cfgEnable,
  input  logic [1:0]        cfgMode,
  input  logic [PSEL_W-1:0] cfgPreSel,
  input  logic [2:0]        cfgOddSel,
  input  logic              cfgEarlyEn,
  input  logic              kick,
  input  logic              intAck,
  input  logic              expire,
  output dpStrobe_t         strobe,
  output logic [2:0]        oddSel,
  output logic [PSEL_W-1:0] preSel,
  output wdtMode_e          modeQ,
  output logic              sysReset,
  output logic              intFlag,
  output logic              earlyFlag
);

  logic enableQ;
  logic earlyEnQ;
  logic intKeep, earlyKeep;
  logic rstNext, intNext, earlyNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ  <= 1'b0;
      earlyEnQ <= 1'b0;
      modeQ    <= MODE_IRQ;
      preSel   <= '0;
      oddSel   <= '0;
    end else if (cfgWr) begin
      enableQ  <= cfgEnable;
      earlyEnQ <= cfgEarlyEn;
      modeQ    <= wdtMode_e'(cfgMode);
      preSel   <= cfgPreSel;
      oddSel   <= cfgOddSel;
    end
  end

  always_comb begin
    strobe.restart = kick;
    strobe.hold    = !enableQ;
  end

  always_comb begin
    intKeep   = intFlag & ~intAck;
    earlyKeep = earlyFlag & ~intAck;
    rstNext   = 1'b0;
    intNext   = intKeep;
    earlyNext = earlyKeep;
    if (expire) begin
      case (modeQ)
        MODE_IRQ: begin
          intNext = 1'b1;
          if (!intKeep) earlyNext = earlyEnQ;
        end
        MODE_RST: begin
          rstNext   = 1'b1;
          intNext   = 1'b0;
          earlyNext = 1'b0;
        end
        default: begin
          if (intKeep) begin
            rstNext   = 1'b1;
            intNext   = 1'b0;
            earlyNext = 1'b0;
          end else begin
            intNext   = 1'b1;
            earlyNext = earlyEnQ;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sysReset  <= 1'b0;
      intFlag   <= 1'b0;
      earlyFlag <= 1'b0;
    end else begin
      sysReset  <= rstNext;
      intFlag   <= intNext;
      earlyFlag <= earlyNext;
    end
  end

endmodule

// File: rtl/wdt_early_warn.sv
module wdt_early_warn
  import wdt_ew_pkg::*;
#(
  parameter int PSEL_W   = 4,
  parameter int PSEL_MAX = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              kick,
  input  logic              cfgWr,
  input  logic              cfgEnable,
  input  logic [1:0]        cfgMode,
  input  logic [PSEL_W-1:0] cfgPreSel,
  input  logic [2:0]        cfgOddSel,
  input  logic              cfgEarlyEn,
  input  logic              intAck,
  output logic              sysReset,
  output logic              intFlag,
  output logic              earlyFlag
);

  dpStrobe_t         strobe;
  logic [2:0]        oddSel;
  logic [PSEL_W-1:0] preSel;
  wdtMode_e          modeQ;
  logic              expire;

  wdt_ew_control #(.PSEL_W(PSEL_W)) u_ctl (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgEnable(cfgEnable),
    .cfgMode(cfgMode), .cfgPreSel(cfgPreSel), .cfgOddSel(cfgOddSel),
    .cfgEarlyEn(cfgEarlyEn), .kick(kick), .intAck(intAck), .expire(expire),
    .strobe(strobe), .oddSel(oddSel), .preSel(preSel), .modeQ(modeQ),
    .sysReset(sysReset), .intFlag(intFlag), .earlyFlag(earlyFlag)
  );

  wdt_ew_datapath #(.PSEL_W(PSEL_W), .PSEL_MAX(PSEL_MAX)) u_dp (
    .clk(clk), .rstN(rstN), .tick(tick), .strobe(strobe),
    .oddSel(oddSel), .preSel(preSel), .expire(expire)
  );

endmodule

// File: rtl/wdt_ew_checker.sv
module wdt_ew_checker
  import wdt_ew_pkg::*;
(
  input logic     clk,
  input logic     rstN,
  input logic     kick,
  input logic     intAck,
  input logic     expire,
  input wdtMode_e modeQ,
  input logic     sysReset,
  input logic     intFlag,
  input logic     earlyFlag
);

  // R11
  reset_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    sysReset |=> !sysReset);

  // R9
  early_needs_int_chk: assert property (@(posedge clk) disable iff (!rstN)
    earlyFlag |-> intFlag);

  // R7
  rst_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (expire && modeQ == MODE_RST) |=> (sysReset && !intFlag));

  // R6
  irq_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (expire && modeQ == MODE_IRQ) |=> (intFlag && !sysReset));

  // R8
  second_expiry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (expire && (modeQ == MODE_TWO || modeQ == MODE_TWO_ALT) && intFlag && !intAck)
      |=> sysReset);

  // R4
  kick_no_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    kick |=> !sysReset);

  // R11
  reset_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysReset) |-> $past(expire));

endmodule

bind wdt_early_warn wdt_ew_checker u_chk (
  .clk(clk), .rstN(rstN), .kick(kick), .intAck(intAck), .expire(expire),
  .modeQ(modeQ), .sysReset(sysReset), .intFlag(intFlag), .earlyFlag(earlyFlag)
);

// File: tb/wdt_early_warn_tb.sv
`timescale 1ns/1ps
module wdt_early_warn_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 0, kick = 0, cfgWr = 0, cfgEnable = 0, cfgEarlyEn = 0, intAck = 0;
  logic [1:0] cfgMode = 0;
  logic [3:0] cfgPreSel = 0;
  logic [2:0] cfgOddSel = 0;
  logic sysReset, intFlag, earlyFlag;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string tag = "R1";

  // model state
  int mOdd, mPre, mMode, mPreSel, mOddSel;
  bit mEn, mEarlyEn, mInt, mEarly, mRst;

  always #2.5 clk = ~clk;

  wdt_early_warn u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .kick(kick), .cfgWr(cfgWr),
    .cfgEnable(cfgEnable), .cfgMode(cfgMode), .cfgPreSel(cfgPreSel),
    .cfgOddSel(cfgOddSel), .cfgEarlyEn(cfgEarlyEn), .intAck(intAck),
    .sysReset(sysReset), .intFlag(intFlag), .earlyFlag(earlyFlag)
  );

  function automatic int oddF(input int sel);
    case (sel)
      1: return 3; 2: return 5; 3: return 7; 4: return 11; 5: return 13;
      default: return 1;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic modelStep();
    bit exp;
    bit keepI, keepE;
    int f, ps, lim;
    exp = 0;
    f = oddF(mOddSel);
    ps = (mPreSel > 9) ? 9 : mPreSel;
    lim = 2 << ps;
    if (!mEn || kick) begin
      mOdd = 0; mPre = 0;
    end else if (tick) begin
      if (mOdd >= f - 1) begin
        mOdd = 0;
        if (mPre >= lim - 1) begin mPre = 0; exp = 1; end
        else mPre++;
      end else mOdd = (mOdd + 1) % 16;
    end
    keepI = mInt && !intAck;
    keepE = mEarly && !intAck;
    mRst = 0; mInt = keepI; mEarly = keepE;
    if (exp) begin
      if (mMode == 0) begin
        mInt = 1;
        if (!keepI) mEarly = mEarlyEn;
      end else if (mMode == 1) begin
        mRst = 1; mInt = 0; mEarly = 0;
      end else if (keepI) begin
        mRst = 1; mInt = 0; mEarly = 0;
      end else begin
        mInt = 1; mEarly = mEarlyEn;
      end
    end
    if (cfgWr) begin
      mEn = cfgEnable; mEarlyEn = cfgEarlyEn; mMode = cfgMode;
      mPreSel = cfgPreSel; mOddSel = cfgOddSel;
    end
  endtask

  // one clock: inputs already driven; compare outputs at the following negedge
  task automatic runCycle();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    check({tag, " sysReset"}, sysReset, mRst);
    check({tag, " intFlag"}, intFlag, mInt);
    check({tag, " earlyFlag"}, earlyFlag, mEarly);
    tick = 0; kick = 0; cfgWr = 0; intAck = 0;
  endtask

  task automatic step(input bit tk, input bit kc, input bit ak);
    tick = tk; kick = kc; intAck = ak;
    runCycle();
  endtask

  task automatic writeCfg(input bit en, input int mode, input int pre,
                          input int odd, input bit early, input bit tk);
    cfgWr = 1; cfgEnable = en; cfgMode = 2'(mode); cfgPreSel = 4'(pre);
    cfgOddSel = 3'(odd); cfgEarlyEn = early; tick = tk;
    runCycle();
  endtask

  // ticks from a restart (kick, or previous reset if noKick) to the reset pulse
  task automatic measure(input bit noKick, output int n);
    n = 0;
    if (!noKick) step(0, 1, 0);
    for (int i = 0; i < 4000; i++) begin
      step(1, 0, 0);
      n++;
      if (sysReset) break;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired R1 actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n, n2;
    void'($urandom(32'd4711));
    mOdd = 0; mPre = 0; mMode = 0; mPreSel = 0; mOddSel = 0;
    mEn = 0; mEarlyEn = 0; mInt = 0; mEarly = 0; mRst = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 sysReset", sysReset, 0);
    check("R1 intFlag", intFlag, 0);
    check("R1 earlyFlag", earlyFlag, 0);
    rstN = 1;
    @(negedge clk);

    // R5: disabled, ticks have no effect
    tag = "R5";
    for (int i = 0; i < 40; i++) step(1, 0, 0);
    check("R5 no reset while disabled", sysReset, 0);

    // R3: factor 3, prescale code 0 -> 6 ticks
    tag = "R3";
    writeCfg(1, 1, 0, 1, 0, 0);
    measure(0, n);
    check("R3 period f3 p0", n, 6);
    // R11: pulse one cycle, restart from zero with same config
    tag = "R11";
    step(0, 0, 0);
    check("R11 pulse one cycle", sysReset, 0);
    measure(1, n2);
    check("R11 same period after reset", n2, 6 - 1 + 1);

    // R2: odd factors
    tag = "R2";
    writeCfg(1, 1, 0, 4, 0, 0);
    measure(0, n);
    check("R2 factor 11", n, 22);
    writeCfg(1, 1, 1, 5, 0, 0);
    measure(0, n);
    check("R3 factor 13 prescale 1", n, 52);
    writeCfg(1, 1, 2, 6, 0, 0);
    measure(0, n);
    check("R2 code 6 acts as 1", n, 8);
    // R2: lower factor mid-period
    writeCfg(1, 1, 0, 5, 0, 0);
    step(0, 1, 0);
    for (int i = 0; i < 8; i++) step(1, 0, 0);
    writeCfg(1, 1, 0, 1, 0, 0);
    step(1, 0, 0);
    step(1, 0, 0);
    step(1, 0, 0);
    step(1, 0, 0);
    check("R2 lowered factor completes period", sysReset, 1);
    // R3: prescale code above 9 clamps
    tag = "R3";
    writeCfg(1, 1, 12, 0, 0, 0);
    measure(0, n);
    check("R3 code 12 acts as 9", n, 1024);

    // R4: kick mid-period and on the would-be expiry tick
    tag = "R4";
    writeCfg(1, 1, 0, 1, 0, 0);
    step(0, 1, 0);
    for (int i = 0; i < 5; i++) step(1, 0, 0);
    step(1, 1, 0);
    check("R4 kick blocks expiry tick", sysReset, 0);
    for (int i = 0; i < 4; i++) step(1, 0, 0);
    measure(0, n);
    check("R4 full period after kick", n, 6);

    // R6: interrupt only
    tag = "R6";
    writeCfg(1, 0, 0, 0, 0, 0);
    step(0, 1, 0);
    step(1, 0, 0); step(1, 0, 0);
    check("R6 flag set", intFlag, 1);
    for (int i = 0; i < 10; i++) step(1, 0, 0);
    check("R6 flag held no reset", intFlag, 1);
    step(0, 0, 1);
    check("R6 ack clears", intFlag, 0);

    // R8 + R9: two-stage with early warning
    tag = "R8";
    writeCfg(1, 2, 0, 0, 1, 0);
    step(0, 1, 0);
    step(1, 0, 0); step(1, 0, 0);
    check("R8 first expiry flag", intFlag, 1);
    check("R9 early set", earlyFlag, 1);
    step(1, 0, 0); step(1, 0, 0);
    check("R8 second expiry resets", sysReset, 1);
    step(1, 0, 0); step(1, 0, 0);
    step(0, 0, 1);
    check("R9 ack clears early", earlyFlag, 0);
    step(1, 0, 0); step(1, 0, 0);
    check("R8 serviced no reset", sysReset, 0);
    tag = "R9";
    writeCfg(1, 3, 0, 0, 0, 0);
    step(0, 0, 1);
    step(1, 0, 0); step(1, 0, 0);
    check("R9 early off", earlyFlag, 0);
    check("R8 mode 3 flag", intFlag, 1);
    step(0, 0, 1);

    // R10: lower prescale without kick
    tag = "R10";
    writeCfg(1, 1, 3, 0, 0, 0);
    step(0, 1, 0);
    for (int i = 0; i < 10; i++) step(1, 0, 0);
    writeCfg(1, 1, 0, 0, 0, 0);
    step(1, 0, 0);
    check("R10 spurious expiry", sysReset, 1);

    // R12: write with tick uses old config
    tag = "R12";
    writeCfg(1, 1, 0, 0, 0, 0);
    step(0, 1, 0);
    step(1, 0, 0);
    writeCfg(1, 0, 0, 0, 0, 1);
    check("R12 old mode used in write cycle", sysReset, 1);
    step(0, 0, 0);

    // random mix
    for (int i = 0; i < 6000; i++) begin
      if (($urandom % 64) == 0) begin
        cfgWr = 1; cfgEnable = ($urandom % 8) != 0; cfgMode = 2'($urandom);
        cfgPreSel = 4'($urandom % 4); cfgOddSel = 3'($urandom);
        cfgEarlyEn = 1'($urandom);
      end
      tag = (mMode == 0) ? "R6" : (mMode == 1) ? "R7" : "R8";
      step(($urandom % 2) == 0, ($urandom % 40) == 0, ($urandom % 12) == 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule